// File: doc/BRIEF.md
# Thread-Block Admission Allocator

This block guards the capacity of one multithreaded compute core. An upstream dispatcher presents one thread block at a time. Each request gives the block's thread count, its registers per thread and its shared-memory bytes. The allocator admits the block only if four separate limits all still hold: a free block slot, enough free thread capacity, enough free registers (registers per thread times thread count) and enough free shared memory. On admission it reserves all four resources as a whole-block unit and returns the slot index it used.

A request that cannot fit now, but could fit on an empty core, is held off with a stall indication. The dispatcher keeps presenting it until it is granted. A request that could never fit is rejected in the same cycle. Later, when the block finishes, the dispatcher returns its slot index on the release port. The slot remembers its own reservation, so the release frees exactly what was taken. A release and a request in the same cycle are resolved release-first. The block also reports the number of resident warps, for use by the warp scheduler.

Top module: `blk_admit_alloc`

## Requirements
- R1: After reset all slots are free, `warps_resident` is 0, and with `req_valid` low none of `req_grant`, `req_stall` or `req_reject` is asserted.
- R2: A valid request that meets every limit asserts `req_grant` in the same cycle. `grant_slot` gives the lowest-numbered slot that is free after this cycle's release, and that slot holds the reservation from the next cycle on.
- R3: The threads of all resident blocks never exceed 768. A request that would exceed this is stalled.
- R4: A block's register demand is registers-per-thread multiplied by thread count. The register demand of all resident blocks never exceeds the 8192-entry pool. A request that would exceed it is stalled.
- R5: The shared-memory bytes of all resident blocks never exceed 16384. A request that would exceed this is stalled.
- R6: At most 8 blocks are resident. A ninth request is stalled even when all other limits hold.
- R7: A request is rejected in the same cycle, and never granted or stalled, if any of the following holds: its thread count is 0 or above 512, its register demand is above 8192, or its shared memory is above 16384.
- R8: In any cycle at most one of `req_grant`, `req_stall`, `req_reject` is high. A valid request gets exactly one of them.
- R9: A release of a resident slot returns that slot's threads, registers, shared memory and warps to the pools. When a release and a request arrive in the same cycle, the released amounts and the released slot are already available to that request.
- R10: On each grant, `warps_resident` rises by ceil(threads/32) on the next cycle. On each release it falls by the released block's warp count.
- R11: A release naming a slot that holds no block has no effect on the pools or on `warps_resident`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Admission request present |
| req_threads | input | 11 | Threads in the requested block |
| req_regs_per_thr | input | 8 | Registers needed per thread |
| req_smem | input | 15 | Shared-memory bytes needed |
| req_grant | output | 1 | Request admitted this cycle |
| req_stall | output | 1 | Request fits later; hold it |
| req_reject | output | 1 | Request can never fit |
| grant_slot | output | 3 | Slot index given on grant |
| rel_valid | input | 1 | Release of a slot |
| rel_slot | input | 3 | Slot being released |
| warps_resident | output | 6 | Warps of all resident blocks |

## Verification
The assertions take for granted that `rel_slot` always names an existing slot when `rel_valid` is high. The stimulus draws release indices only from the slot range. The assertions also rely on the pool counters starting from reset, so every bench phase begins with a reset. Random requests mix sizes below and above the per-block limit and register and shared-memory demands near the pool sizes, so grants, stalls and rejects all occur. Some releases deliberately name empty slots, and some land in the same cycle as a request.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

   typedef enum logic [1:0] {
      DEC_IDLE   = 2'd0,
      DEC_GRANT  = 2'd1,
      DEC_STALL  = 2'd2,
      DEC_REJECT = 2'd3
   } admit_dec_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ba_slot_table.sv
module ba_slot_table #(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 3,
   parameter int THR_W  = 10,
   parameter int REG_W  = 14,
   parameter int SM_W   = 15,
   parameter int WRP_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [SLOT_W-1:0] alloc_slot,
   input  logic [THR_W-1:0]  alloc_thr,
   input  logic [REG_W-1:0]  alloc_reg,
   input  logic [SM_W-1:0]   alloc_sm,
   input  logic [WRP_W-1:0]  alloc_wrp,
   input  logic              free_en,
   input  logic [SLOT_W-1:0] free_slot,
   output logic [SLOTS-1:0]  busy,
   output logic              rel_hit,
   output logic [THR_W-1:0]  rel_thr,
   output logic [REG_W-1:0]  rel_reg,
   output logic [SM_W-1:0]   rel_sm,
   output logic [WRP_W-1:0]  rel_wrp
);

   logic [THR_W-1:0] thr_q [SLOTS];
   logic [REG_W-1:0] reg_q [SLOTS];
   logic [SM_W-1:0]  sm_q  [SLOTS];
   logic [WRP_W-1:0] wrp_q [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic take_s, drop_s;
      assign take_s = alloc_en && (alloc_slot == SLOT_W'(s));
      assign drop_s = free_en && (free_slot == SLOT_W'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy[s]  <= 1'b0;
            thr_q[s] <= '0;
            reg_q[s] <= '0;
            sm_q[s]  <= '0;
            wrp_q[s] <= '0;
         end else if (take_s) begin
            busy[s]  <= 1'b1;
            thr_q[s] <= alloc_thr;
            reg_q[s] <= alloc_reg;
            sm_q[s]  <= alloc_sm;
            wrp_q[s] <= alloc_wrp;
         end else if (drop_s) begin
            busy[s]  <= 1'b0;
            thr_q[s] <= '0;
            reg_q[s] <= '0;
            sm_q[s]  <= '0;
            wrp_q[s] <= '0;
         end
      end
   end

   always_comb begin
      rel_hit = 1'b0;
      rel_thr = '0;
      rel_reg = '0;
      rel_sm  = '0;
      rel_wrp = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (free_en && busy[s] && (free_slot == SLOT_W'(s))) begin
            rel_hit = 1'b1;
            rel_thr = thr_q[s];
            rel_reg = reg_q[s];
            rel_sm  = sm_q[s];
            rel_wrp = wrp_q[s];
         end
      end
   end

endmodule

// File: rtl/ba_pick_low.sv
module ba_pick_low #(
   parameter int SLOTS  = 8,
   parameter int SLOT_W = 3
) (
   input  logic [SLOTS-1:0]  avail,
   output logic              any,
   output logic [SLOT_W-1:0] idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (avail[s]) begin
            any = 1'b1;
            idx = SLOT_W'(s);
         end
      end
   end

endmodule

// File: rtl/ba_fit_check.sv
module ba_fit_check
   import blk_admit_pkg::*;
#(
   parameter int REQ_THR_W   = 11,
   parameter int RPT_W       = 8,
   parameter int SMEM_W      = 15,
   parameter int THR_W       = 10,
   parameter int REG_W       = 14,
   parameter int SM_W        = 15,
   parameter int WRP_W       = 6,
   parameter int REG_POOL    = 8192,
   parameter int SMEM_POOL   = 16384,
   parameter int BLK_THR_MAX = 512,
   parameter int MAX_THR     = 768,
   parameter int WARP_SZ     = 32
) (
   input  logic                 req_valid,
   input  logic [REQ_THR_W-1:0] thr,
   input  logic [RPT_W-1:0]     rpt,
   input  logic [SMEM_W-1:0]    sm,
   input  logic [THR_W:0]       free_thr,
   input  logic [REG_W:0]       free_reg,
   input  logic [SM_W:0]        free_sm,
   input  logic                 slot_avail,
   output admit_dec_e           dec,
   output logic [THR_W-1:0]     dem_thr,
   output logic [REG_W-1:0]     dem_reg,
   output logic [SM_W-1:0]      dem_sm,
   output logic [WRP_W-1:0]     dem_wrp
);

   localparam int DEM_W  = REQ_THR_W + RPT_W;
   localparam int WIDE_W = DEM_W + 2;
   localparam int WSH    = $clog2(WARP_SZ);

   logic [DEM_W-1:0]     reg_full;
   logic [REQ_THR_W-1:0] wrp_full;
   logic                 never_fits, fits_now;

   assign reg_full = DEM_W'(thr) * DEM_W'(rpt);

   if (is_pow2(WARP_SZ)) begin : g_wrp_shift
      assign wrp_full = (thr >> WSH) + REQ_THR_W'(|thr[WSH-1:0]);
   end else begin : g_wrp_div
      assign wrp_full = REQ_THR_W'((32'(thr) + WARP_SZ - 1) / WARP_SZ);
   end

   assign never_fits = (thr == '0)
                    || (WIDE_W'(thr) > WIDE_W'(BLK_THR_MAX))
                    || (WIDE_W'(thr) > WIDE_W'(MAX_THR))
                    || (WIDE_W'(reg_full) > WIDE_W'(REG_POOL))
                    || (WIDE_W'(sm) > WIDE_W'(SMEM_POOL));

   assign fits_now = slot_avail
                  && (WIDE_W'(thr) <= WIDE_W'(free_thr))
                  && (WIDE_W'(reg_full) <= WIDE_W'(free_reg))
                  && (WIDE_W'(sm) <= WIDE_W'(free_sm));

   always_comb begin
      if (!req_valid)      dec = DEC_IDLE;
      else if (never_fits) dec = DEC_REJECT;
      else if (fits_now)   dec = DEC_GRANT;
      else                 dec = DEC_STALL;
   end

   assign dem_thr = THR_W'(thr);
   assign dem_reg = REG_W'(reg_full);
   assign dem_sm  = SM_W'(sm);
   assign dem_wrp = WRP_W'(wrp_full);

endmodule

// File: rtl/blk_admit_alloc.sv
module blk_admit_alloc
   import blk_admit_pkg::*;
#(
   parameter int SLOTS       = 8,
   parameter int MAX_THR     = 768,
   parameter int REG_POOL    = 8192,
   parameter int SMEM_POOL   = 16384,
   parameter int BLK_THR_MAX = 512,
   parameter int WARP_SZ     = 32,
   parameter int REQ_THR_W   = 11,
   parameter int RPT_W       = 8,
   parameter int SMEM_W      = 15,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int WRP_W  = $clog2(MAX_THR / WARP_SZ + SLOTS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [REQ_THR_W-1:0] req_threads,
   input  logic [RPT_W-1:0]     req_regs_per_thr,
   input  logic [SMEM_W-1:0]    req_smem,
   output logic                 req_grant,
   output logic                 req_stall,
   output logic                 req_reject,
   output logic [SLOT_W-1:0]    grant_slot,
   input  logic                 rel_valid,
   input  logic [SLOT_W-1:0]    rel_slot,
   output logic [WRP_W-1:0]     warps_resident
);

   localparam int THR_W = $clog2(MAX_THR + 1);
   localparam int REG_W = $clog2(REG_POOL + 1);
   localparam int SM_W  = $clog2(SMEM_POOL + 1);

   initial begin
      assert (SLOTS >= 1) else $error("SLOTS must be at least 1");
      assert (WARP_SZ >= 2) else $error("WARP_SZ must be at least 2");
      assert (BLK_THR_MAX <= MAX_THR) else $error("per-block limit above core limit");
      assert ((1 << REQ_THR_W) > BLK_THR_MAX) else $error("REQ_THR_W too narrow");
      assert (SM_W <= SMEM_W + 1) else $error("SMEM_W too narrow for pool");
   end

   logic [THR_W-1:0] used_thr;
   logic [REG_W-1:0] used_reg;
   logic [SM_W-1:0]  used_sm;
   logic [WRP_W-1:0] used_wrp;

   logic [SLOTS-1:0] slot_busy, slot_avail;
   logic             rel_hit;
   logic [THR_W-1:0] rel_thr, dem_thr;
   logic [REG_W-1:0] rel_reg, dem_reg;
   logic [SM_W-1:0]  rel_sm, dem_sm;
   logic [WRP_W-1:0] rel_wrp, dem_wrp;
   logic             any_free;
   logic [SLOT_W-1:0] pick_idx;
   logic [THR_W:0]   free_thr;
   logic [REG_W:0]   free_reg;
   logic [SM_W:0]    free_sm;
   admit_dec_e       dec;

   ba_slot_table #(
      .SLOTS(SLOTS), .SLOT_W(SLOT_W), .THR_W(THR_W),
      .REG_W(REG_W), .SM_W(SM_W), .WRP_W(WRP_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(req_grant), .alloc_slot(pick_idx),
      .alloc_thr(dem_thr), .alloc_reg(dem_reg),
      .alloc_sm(dem_sm), .alloc_wrp(dem_wrp),
      .free_en(rel_valid), .free_slot(rel_slot),
      .busy(slot_busy), .rel_hit(rel_hit),
      .rel_thr(rel_thr), .rel_reg(rel_reg),
      .rel_sm(rel_sm), .rel_wrp(rel_wrp)
   );

   always_comb begin
      slot_avail = ~slot_busy;
      for (int s = 0; s < SLOTS; s++) begin
         if (rel_hit && (rel_slot == SLOT_W'(s))) slot_avail[s] = 1'b1;
      end
   end

   ba_pick_low #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
      .avail(slot_avail), .any(any_free), .idx(pick_idx)
   );

   assign free_thr = (THR_W+1)'(MAX_THR) - (THR_W+1)'(used_thr) + (THR_W+1)'(rel_thr);
   assign free_reg = (REG_W+1)'(REG_POOL) - (REG_W+1)'(used_reg) + (REG_W+1)'(rel_reg);
   assign free_sm  = (SM_W+1)'(SMEM_POOL) - (SM_W+1)'(used_sm) + (SM_W+1)'(rel_sm);

   ba_fit_check #(
      .REQ_THR_W(REQ_THR_W), .RPT_W(RPT_W), .SMEM_W(SMEM_W),
      .THR_W(THR_W), .REG_W(REG_W), .SM_W(SM_W), .WRP_W(WRP_W),
      .REG_POOL(REG_POOL), .SMEM_POOL(SMEM_POOL),
      .BLK_THR_MAX(BLK_THR_MAX), .MAX_THR(MAX_THR), .WARP_SZ(WARP_SZ)
   ) u_fit (
      .req_valid(req_valid), .thr(req_threads), .rpt(req_regs_per_thr),
      .sm(req_smem), .free_thr(free_thr), .free_reg(free_reg),
      .free_sm(free_sm), .slot_avail(any_free), .dec(dec),
      .dem_thr(dem_thr), .dem_reg(dem_reg), .dem_sm(dem_sm), .dem_wrp(dem_wrp)
   );

   assign req_grant  = (dec == DEC_GRANT);
   assign req_stall  = (dec == DEC_STALL);
   assign req_reject = (dec == DEC_REJECT);
   assign grant_slot = pick_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_thr <= '0;
         used_reg <= '0;
         used_sm  <= '0;
         used_wrp <= '0;
      end else begin
         used_thr <= used_thr - rel_thr + (req_grant ? dem_thr : '0);
         used_reg <= used_reg - rel_reg + (req_grant ? dem_reg : '0);
         used_sm  <= used_sm  - rel_sm  + (req_grant ? dem_sm  : '0);
         used_wrp <= used_wrp - rel_wrp + (req_grant ? dem_wrp : '0);
      end
   end

   assign warps_resident = used_wrp;

endmodule

// File: rtl/ba_checker.sv
module ba_checker #(
   parameter int SLOTS       = 8,
   parameter int SLOT_W      = 3,
   parameter int MAX_THR     = 768,
   parameter int REG_POOL    = 8192,
   parameter int SMEM_POOL   = 16384,
   parameter int BLK_THR_MAX = 512,
   parameter int REQ_THR_W   = 11,
   parameter int THR_W       = 10,
   parameter int REG_W       = 14,
   parameter int SM_W        = 15,
   parameter int WRP_W       = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic [REQ_THR_W-1:0] req_threads,
   input logic                 grant,
   input logic                 stall,
   input logic                 reject,
   input logic [SLOT_W-1:0]    grant_slot,
   input logic                 rel_valid,
   input logic [SLOT_W-1:0]    rel_slot,
   input logic [SLOTS-1:0]     busy,
   input logic                 rel_hit,
   input logic [THR_W-1:0]     used_thr,
   input logic [REG_W-1:0]     used_reg,
   input logic [SM_W-1:0]      used_sm,
   input logic [WRP_W-1:0]     warps,
   input logic [WRP_W-1:0]     dem_wrp
);

   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, stall, reject}));

   assert_thr_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(used_thr) <= MAX_THR);

   assert_reg_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(used_reg) <= REG_POOL);

   assert_sm_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(used_sm) <= SMEM_POOL);

   assert_big_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (32'(req_threads) > BLK_THR_MAX)) |-> reject);

   assert_slot_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (!busy[grant_slot] || (rel_hit && (rel_slot == grant_slot))));

   assert_slot_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant |=> busy[$past(grant_slot)]);

   assert_warp_up_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !rel_valid) |=> (warps == $past(warps) + $past(dem_wrp)));

   assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !rel_hit && !grant) |=> $stable(warps));

endmodule

bind blk_admit_alloc ba_checker #(
   .SLOTS(SLOTS), .SLOT_W(SLOT_W), .MAX_THR(MAX_THR), .REG_POOL(REG_POOL),
   .SMEM_POOL(SMEM_POOL), .BLK_THR_MAX(BLK_THR_MAX), .REQ_THR_W(REQ_THR_W),
   .THR_W(THR_W), .REG_W(REG_W), .SM_W(SM_W), .WRP_W(WRP_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
   .grant(req_grant), .stall(req_stall), .reject(req_reject),
   .grant_slot(grant_slot), .rel_valid(rel_valid), .rel_slot(rel_slot),
   .busy(slot_busy), .rel_hit(rel_hit), .used_thr(used_thr),
   .used_reg(used_reg), .used_sm(used_sm), .warps(warps_resident),
   .dem_wrp(dem_wrp)
);

// File: tb/blk_admit_alloc_bench.sv
module blk_admit_alloc_bench;

   localparam int CLK_NS = 10;
   localparam int NS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [10:0] req_threads = '0;
   logic [7:0]  req_regs_per_thr = '0;
   logic [14:0] req_smem = '0;
   logic        req_grant, req_stall, req_reject;
   logic [2:0]  grant_slot;
   logic        rel_valid = 1'b0;
   logic [2:0]  rel_slot = '0;
   logic [5:0]  warps_resident;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   int m_busy [NS];
   int m_thr [NS];
   int m_reg [NS];
   int m_sm [NS];
   int m_wrp [NS];
   string wtag = "R1";

   always #(CLK_NS/2) clk = ~clk;

   blk_admit_alloc u_blk_admit_alloc (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_threads(req_threads), .req_regs_per_thr(req_regs_per_thr),
      .req_smem(req_smem), .req_grant(req_grant), .req_stall(req_stall),
      .req_reject(req_reject), .grant_slot(grant_slot),
      .rel_valid(rel_valid), .rel_slot(rel_slot),
      .warps_resident(warps_resident)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int sum_of(input int which);
      int t = 0;
      for (int i = 0; i < NS; i++) begin
         if (m_busy[i] != 0) begin
            case (which)
               0: t += m_thr[i];
               1: t += m_reg[i];
               2: t += m_sm[i];
               default: t += m_wrp[i];
            endcase
         end
      end
      return t;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      rel_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NS; i++) m_busy[i] = 0;
      wtag = "R1";
   endtask

   // one cycle: drive, compare against the model, advance the model
   task automatic step(input bit rv, input int rs, input bit qv, input int thr,
                       input int rpt, input int sm, output int got_slot);
      bit hit, never, slot_ok;
      int fthr, freg, fsm, slot, dreg;
      int eg, es, er;
      string tag;
      @(negedge clk);
      rel_valid = rv;
      rel_slot = 3'(rs);
      req_valid = qv;
      req_threads = 11'(thr);
      req_regs_per_thr = 8'(rpt);
      req_smem = 15'(sm);
      #1;
      hit = rv && (m_busy[rs] != 0);
      fthr = 768 - sum_of(0) + (hit ? m_thr[rs] : 0);
      freg = 8192 - sum_of(1) + (hit ? m_reg[rs] : 0);
      fsm = 16384 - sum_of(2) + (hit ? m_sm[rs] : 0);
      dreg = thr * rpt;
      slot = -1;
      for (int i = NS - 1; i >= 0; i--) begin
         if (m_busy[i] == 0 || (hit && i == rs)) slot = i;
      end
      slot_ok = (slot >= 0);
      never = (thr == 0) || (thr > 512) || (dreg > 8192) || (sm > 16384);
      eg = 0; es = 0; er = 0;
      if (qv) begin
         if (never) begin er = 1; tag = "R7"; end
         else if (!slot_ok) begin es = 1; tag = "R6"; end
         else if (thr > fthr) begin es = 1; tag = "R3"; end
         else if (dreg > freg) begin es = 1; tag = "R4"; end
         else if (sm > fsm) begin es = 1; tag = "R5"; end
         else begin eg = 1; tag = hit ? "R9" : "R2"; end
      end else tag = "R1";
      chk({wtag, " warps_resident"}, int'(warps_resident), sum_of(3));
      chk({tag, " grant"}, int'(req_grant), eg);
      chk({tag, " stall"}, int'(req_stall), es);
      chk({"R8 ", tag, " reject"}, int'(req_reject), er);
      if (eg != 0) chk({tag, " grant_slot"}, int'(grant_slot), slot);
      got_slot = (req_grant) ? int'(grant_slot) : -1;
      @(posedge clk);
      if (hit) m_busy[rs] = 0;
      if (eg != 0) begin
         m_busy[slot] = 1;
         m_thr[slot] = thr;
         m_reg[slot] = dreg;
         m_sm[slot] = sm;
         m_wrp[slot] = (thr + 31) / 32;
      end
      if (rv && !hit) wtag = "R11";
      else if (hit) wtag = "R9";
      else wtag = "R10";
   endtask

   initial begin
      #(CLK_NS * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      void'($urandom(1234));
      do_reset();
      // R1: quiet after reset
      #1;
      chk("R1 grant idle", int'(req_grant), 0);
      chk("R1 stall idle", int'(req_stall), 0);
      chk("R1 reject idle", int'(req_reject), 0);
      chk("R1 warps", int'(warps_resident), 0);

      // R3: three 256-thread blocks fill threads, a fourth stalls
      for (int i = 0; i < 3; i++) step(0, 0, 1, 256, 1, 0, s);
      step(0, 0, 1, 64, 1, 0, s);
      chk("R3 stall at 768 threads", s, -1);
      // R9: same-cycle release of slot 1 lets the held request in, into slot 1
      step(1, 1, 1, 64, 1, 0, s);
      chk("R9 reuse released slot", s, 1);
      step(0, 0, 0, 0, 0, 0, s);
      chk("R10 warps after reuse", int'(warps_resident), 8 + 8 + 2);

      // R4: 11 registers x 256 threads, third block stalls on registers
      do_reset();
      for (int i = 0; i < 2; i++) step(0, 0, 1, 256, 11, 0, s);
      step(0, 0, 1, 256, 11, 0, s);
      chk("R4 register stall", s, -1);

      // R5: shared memory pool
      do_reset();
      for (int i = 0; i < 2; i++) step(0, 0, 1, 16, 1, 8192, s);
      step(0, 0, 1, 16, 1, 1, s);
      chk("R5 smem stall", s, -1);

      // R6: nine small blocks, ninth stalls
      do_reset();
      for (int i = 0; i < 8; i++) step(0, 0, 1, 16, 1, 0, s);
      step(0, 0, 1, 16, 1, 0, s);
      chk("R6 slot stall", s, -1);

      // R7: permanent rejects
      do_reset();
      step(0, 0, 1, 1024, 1, 0, s);
      step(0, 0, 1, 513, 1, 0, s);
      step(0, 0, 1, 0, 1, 0, s);
      step(0, 0, 1, 512, 17, 0, s);
      step(0, 0, 1, 32, 1, 16385, s);
      // R10: ceil rounding, 33 threads -> 2 warps
      step(0, 0, 1, 33, 1, 0, s);
      step(0, 0, 0, 0, 0, 0, s);
      chk("R10 ceil warps", int'(warps_resident), 2);
      // R11: release of an empty slot
      step(1, 5, 0, 0, 0, 0, s);
      step(0, 0, 0, 0, 0, 0, s);
      chk("R11 empty release", int'(warps_resident), 2);

      // random phase
      do_reset();
      for (int c = 0; c < 4000; c++) begin
         int thr, rpt, sm, pick;
         bit rv, qv;
         pick = int'($urandom_range(0, 9));
         case (pick)
            0: thr = 1024;
            1: thr = 513;
            2: thr = 512;
            3: thr = 256;
            4: thr = 128;
            default: thr = int'($urandom_range(1, 300));
         endcase
         rpt = int'($urandom_range(1, 24));
         sm = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 17000))
                                          : int'($urandom_range(0, 4096));
         qv = ($urandom_range(0, 3) != 0);
         rv = ($urandom_range(0, 2) == 0);
         step(rv, int'($urandom_range(0, NS - 1)), qv, thr, rpt, sm, s);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule